// File: doc/BRIEF.md
# Temperature Sensor Two-Wire Register Slave

This block is the bus-facing half of a digital temperature sensor. It sits on an I2C/SMBus bus as a target device. The system clock oversamples SCL and SDA, and the block answers to a 7-bit address built from a fixed prefix and three select inputs. It exposes a small register file through a persistent register pointer:
- a read-only temperature value taken from the converter,
- an 8-bit configuration byte,
- two 16-bit limits (hysteresis and trip),
- a write-only one-shot location whose only effect is a request pulse.

The block drives SDA only through a pull-low enable. The pad and the pull-up are outside it. It never stretches the clock.

The converter-side logic uses two pulses from the block. The read strobe lets the alert logic clear a latched interrupt. The one-shot request starts a single conversion while the sensor is powered down. When SDA stays low during a transaction for a set number of system clocks, the block releases the line and waits for a new start condition.

The controller is one state machine with seven states:
- `ST_IDLE`: waits for a start.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the address acknowledge.
- `ST_WR_BYTE`: shifts in a written byte.
- `ST_WR_ACK`: acknowledges a written byte.
- `ST_RD_BYTE`: shifts out a read byte.
- `ST_RD_ACK`: samples the controller's acknowledge.

Its transitions are:
- A start condition from any state goes to `ST_ADDR`.
- A stop condition or a timeout from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on the SCL fall after eight bits if the address matches, and otherwise to `ST_IDLE`.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` or `ST_WR_BYTE`, chosen by the direction bit, on the next SCL fall.
- `ST_WR_BYTE` goes to `ST_WR_ACK` after eight bits.
- `ST_WR_ACK` goes back to `ST_WR_BYTE` on the next SCL fall.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes back to `ST_RD_BYTE` if the controller acknowledged, and otherwise to `ST_IDLE`.

Top module: `tsense_i2c_slave`

## Requirements
- R1: After reset the configuration output is 0x00, the hysteresis output is 0x4B00, the trip output is 0x5000, the pointer selects the temperature value, and SDA is not pulled.
- R2: The block acknowledges only the 7-bit address 1001 followed by `addr_sel_i[2:0]`, MSB first, with the R/W bit last (1 = read). The select inputs are compared live at every address byte. For any other address the block never pulls SDA.
- R3: The first data byte of a write loads the pointer from bits 2:0; the pointer survives across transactions. Codes: 0 temperature, 1 configuration, 2 hysteresis, 3 trip, 4 one-shot, 5-7 unused. A read uses the stored pointer.
- R4: A 16-bit register reads as high byte then low byte, and continued reads alternate high and low. The configuration register returns the same byte on every read. A write places the first data byte in bits 15:8 and the second in bits 7:0.
- R5: The temperature value is captured when a read address is acknowledged, so both bytes of one read come from the same sample. Writes to pointer 0 are acknowledged and change nothing.
- R6: Configuration bits 7:6 always read 0, and bits 3:0 of both limit registers always read 0, whatever is written.
- R7: A pointer write followed by a repeated start and a read returns the register that was just selected.
- R8: After the controller does not acknowledge a read byte, the block leaves SDA released until the next start.
- R9: Each acknowledged read address produces exactly one single-cycle `rd_strobe_o` pulse; writes produce none.
- R10: Writing pointer value 4 and writing any data byte while the pointer is 4 each produce one single-cycle `oneshot_o` pulse. The data is discarded, and reads of pointers 4 to 7 return 0x00.
- R11: If SDA stays low for TIMEOUT_CYC system clocks during a transaction, the block releases SDA and returns to idle, and the next start is served normally.
- R12: SCL or SDA pulses shorter than FILT_LEN system clocks have no effect on the transaction.
- R13: Every data byte of an addressed write is acknowledged, including bytes beyond the selected register's width, which are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| addr_sel_i | input | 3 | Low three bits of the device address |
| temp_i | input | 16 | Current temperature value from the converter |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| cfg_o | output | 8 | Configuration register |
| hyst_o | output | 16 | Hysteresis limit register |
| trip_o | output | 16 | Trip limit register |
| rd_strobe_o | output | 1 | One-cycle pulse per addressed read |
| oneshot_o | output | 1 | One-cycle one-shot conversion request |

## Verification
A wrong pointer or a wrong write-byte index shows up on the register outputs within one byte. It also shows in the next read's data, because the bench model predicts every byte of every pointer and read position. A wrong state-machine branch shows within one bit time as a missing or extra acknowledge, or as the slave still driving SDA after a not-acknowledge. A lost timeout is bounded by a pull-duration counter and shows up as SDA still held past the limit. A filter that passes short pulses corrupts the byte written in the same transaction.

// File: rtl/tsi2c_pkg.sv
package tsi2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } bus_st_t;

    localparam logic [3:0] DEV_PREFIX = 4'b1001;

    localparam logic [2:0] PTR_TEMP  = 3'd0;
    localparam logic [2:0] PTR_CFG   = 3'd1;
    localparam logic [2:0] PTR_HYST  = 3'd2;
    localparam logic [2:0] PTR_TRIP  = 3'd3;
    localparam logic [2:0] PTR_SHOT  = 3'd4;

endpackage

// File: rtl/tsi2c_glitch_filter.sv
module tsi2c_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == line_o) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                line_o <= sync_q[1];
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tsi2c_bus_events.sv
module tsi2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign start_o = scl_q & scl_f & sda_q & ~sda_f;
    assign stop_o  = scl_q & scl_f & ~sda_q & sda_f;
    assign rise_o  = ~scl_q & scl_f;
    assign fall_o  = scl_q & ~scl_f;
endmodule

// File: rtl/tsense_i2c_slave.sv
module tsense_i2c_slave
    import tsi2c_pkg::*;
#(
    parameter int          FILT_LEN    = 3,
    parameter int          TIMEOUT_CYC = 1_500_000,
    parameter logic [15:0] HYST_RST    = 16'h4B00,
    parameter logic [15:0] TRIP_RST    = 16'h5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [2:0]  addr_sel_i,
    input  logic [15:0] temp_i,
    output logic        sda_pull_o,
    output logic [7:0]  cfg_o,
    output logic [15:0] hyst_o,
    output logic [15:0] trip_o,
    output logic        rd_strobe_o,
    output logic        oneshot_o
);
    localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
    localparam int NLINE = 2;

    logic [NLINE-1:0] raw_lines, filt_lines;
    logic scl_f, sda_f;
    logic ev_start, ev_stop, ev_rise, ev_fall;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_filt
        tsi2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    tsi2c_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall)
    );

    bus_st_t     st_q, st_d;
    logic [3:0]  bit_q;
    logic [7:0]  rx_q, tx_q;
    logic [1:0]  widx_q;
    logic        rd_hi_q, mack_q, pull_q;
    logic [2:0]  ptr_q;
    logic [15:0] snap_q, hyst_q, trip_q;
    logic [7:0]  cfg_q, rd_byte;
    logic [TO_W-1:0] to_q;
    logic        to_hit, addr_ok;

    assign addr_ok = (rx_q[7:1] == {DEV_PREFIX, addr_sel_i});
    assign to_hit  = (st_q != ST_IDLE) && !sda_f && (to_q == TO_W'(TIMEOUT_CYC - 1));

    // low-time counter for the stuck-SDA timeout
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        to_q <= '0;
        else if (st_q == ST_IDLE || sda_f) to_q <= '0;
        else if (!to_hit)                  to_q <= to_q + 1'b1;
    end

    always_comb begin
        unique case (ptr_q)
            PTR_TEMP: rd_byte = rd_hi_q ? snap_q[15:8] : snap_q[7:0];
            PTR_CFG:  rd_byte = cfg_q;
            PTR_HYST: rd_byte = rd_hi_q ? hyst_q[15:8] : hyst_q[7:0];
            PTR_TRIP: rd_byte = rd_hi_q ? trip_q[15:8] : trip_q[7:0];
            default:  rd_byte = 8'h00;
        endcase
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (ev_stop || to_hit) begin
            st_d = ST_IDLE;
        end else if (ev_start) begin
            st_d = ST_ADDR;
        end else begin
            unique case (st_q)
                ST_IDLE:     st_d = ST_IDLE;
                ST_ADDR:     if (ev_fall && bit_q == 4'd8) st_d = addr_ok ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (ev_fall) st_d = rx_q[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (ev_fall && bit_q == 4'd8) st_d = ST_WR_ACK;
                ST_WR_ACK:   if (ev_fall) st_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (ev_fall && bit_q == 4'd7) st_d = ST_RD_ACK;
                ST_RD_ACK:   if (ev_fall) st_d = mack_q ? ST_RD_BYTE : ST_IDLE;
                default:     st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;  rx_q <= '0;  tx_q <= '0;  widx_q <= '0;
            rd_hi_q <= 1'b1;  mack_q <= 1'b0;  pull_q <= 1'b0;
            ptr_q <= PTR_TEMP;  snap_q <= '0;  cfg_q <= '0;
            hyst_q <= HYST_RST;  trip_q <= TRIP_RST;
            rd_strobe_o <= 1'b0;  oneshot_o <= 1'b0;
        end else begin
            rd_strobe_o <= 1'b0;
            oneshot_o   <= 1'b0;
            if (ev_stop || to_hit) begin
                pull_q <= 1'b0;
            end else if (ev_start) begin
                bit_q <= '0;  pull_q <= 1'b0;  widx_q <= '0;  rd_hi_q <= 1'b1;
            end else begin
                unique case (st_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (ev_rise) begin
                            rx_q  <= {rx_q[6:0], sda_f};
                            bit_q <= bit_q + 1'b1;
                        end else if (ev_fall && bit_q == 4'd8) begin
                            if (st_q == ST_ADDR) begin
                                pull_q <= addr_ok;
                                if (addr_ok && rx_q[0]) begin
                                    rd_strobe_o <= 1'b1;
                                    snap_q      <= temp_i;
                                end
                            end else begin
                                pull_q <= 1'b1;
                                if (widx_q != 2'd3) widx_q <= widx_q + 1'b1;
                                if (widx_q == 2'd0) begin
                                    ptr_q     <= rx_q[2:0];
                                    oneshot_o <= (rx_q[2:0] == PTR_SHOT);
                                end else if (ptr_q == PTR_SHOT) begin
                                    oneshot_o <= 1'b1;
                                end else if (widx_q == 2'd1) begin
                                    if (ptr_q == PTR_CFG)  cfg_q         <= {2'b00, rx_q[5:0]};
                                    if (ptr_q == PTR_HYST) hyst_q[15:8]  <= rx_q;
                                    if (ptr_q == PTR_TRIP) trip_q[15:8]  <= rx_q;
                                end else if (widx_q == 2'd2) begin
                                    if (ptr_q == PTR_HYST) hyst_q[7:0]   <= {rx_q[7:4], 4'b0000};
                                    if (ptr_q == PTR_TRIP) trip_q[7:0]   <= {rx_q[7:4], 4'b0000};
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_RD_ACK: begin
                        if (ev_rise && st_q == ST_RD_ACK) begin
                            mack_q <= ~sda_f;
                        end else if (ev_fall) begin
                            bit_q <= '0;
                            if ((st_q == ST_ADDR_ACK && rx_q[0]) || (st_q == ST_RD_ACK && mack_q)) begin
                                tx_q    <= rd_byte;
                                pull_q  <= ~rd_byte[7];
                                rd_hi_q <= ~rd_hi_q;
                            end else begin
                                pull_q <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev_fall) begin
                            pull_q <= 1'b0;
                            bit_q  <= '0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev_fall) begin
                            pull_q <= (bit_q == 4'd7) ? 1'b0 : ~tx_q[6];
                            tx_q   <= {tx_q[6:0], 1'b0};
                            bit_q  <= bit_q + 1'b1;
                        end
                    end
                    default: pull_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_pull_o = pull_q;
    assign cfg_o      = cfg_q;
    assign hyst_o     = hyst_q;
    assign trip_o     = trip_q;
endmodule

// File: rtl/tsense_i2c_slave_chk.sv
module tsense_i2c_slave_chk #(
    parameter int TIMEOUT_CYC = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_pull_o,
    input logic        rd_strobe_o,
    input logic        oneshot_o,
    input logic [7:0]  cfg_o,
    input logic [15:0] hyst_o,
    input logic [15:0] trip_o
);
    localparam int HOLD_MAX = TIMEOUT_CYC + 16;
    localparam int HW       = $clog2(HOLD_MAX + 2);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          hold_q <= '0;
        else if (!sda_pull_o)                hold_q <= '0;
        else if (hold_q != HW'(HOLD_MAX + 1)) hold_q <= hold_q + 1'b1;
    end

    a_r11_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q <= HW'(HOLD_MAX));

    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe_o |=> !rd_strobe_o);

    a_r10_shot_single: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot_o |=> !oneshot_o);

    a_r9_strobe_not_shot: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe_o && oneshot_o));

    a_r6_cfg_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[7:6] == 2'b00);

    a_r6_limit_low: assert property (@(posedge clk) disable iff (!rst_n)
        hyst_o[3:0] == 4'h0 && trip_o[3:0] == 4'h0);
endmodule

bind tsense_i2c_slave tsense_i2c_slave_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_pull_o  (sda_pull_o),
    .rd_strobe_o (rd_strobe_o),
    .oneshot_o   (oneshot_o),
    .cfg_o       (cfg_o),
    .hyst_o      (hyst_o),
    .trip_o      (trip_o)
);

// File: tb/test_tsense_i2c_slave.sv
`timescale 1ns/1ps
module test_tsense_i2c_slave;
    localparam int Q  = 12;
    localparam int TO = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic [2:0]  sel = 3'd5;
    logic [15:0] temp = 16'h19A0;
    logic        sda_pull, rd_strobe, oneshot;
    logic [7:0]  cfg;
    logic [15:0] hyst, trip;
    wire         sda_line = m_sda & ~sda_pull;

    int n_tests = 0, n_fail = 0, os_cnt = 0, rd_cnt = 0, rd_exp = 0, os_exp = 0;
    logic [7:0] exp_cfg = 8'h00;
    logic [15:0] exp_hyst = 16'h4B00, exp_trip = 16'h5000;
    logic ack;
    int nacks;
    logic [7:0] r0, r1, r2;

    always #10 clk = ~clk;

    tsense_i2c_slave #(.FILT_LEN(3), .TIMEOUT_CYC(TO)) i_tsense_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .addr_sel_i(sel),
        .temp_i(temp), .sda_pull_o(sda_pull), .cfg_o(cfg), .hyst_o(hyst), .trip_o(trip),
        .rd_strobe_o(rd_strobe), .oneshot_o(oneshot)
    );

    always @(negedge clk) begin
        if (rst_n && oneshot)   os_cnt++;
        if (rst_n && rd_strobe) rd_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = Q);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic wbyte(input logic [7:0] b, input bit gl, output logic a);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(); m_scl = 1'b1; wq();
            if (gl && i == 3) begin
                m_sda = ~m_sda; wq(2); m_sda = ~m_sda;
            end
            wq(); m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); a = ~sda_line; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic rbyte(input bit nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b[i] = sda_line; wq(); m_scl = 1'b0; wq();
        end
        m_sda = nack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq(); m_sda = 1'b1;
    endtask

    task automatic wr_seq(input logic [7:0] p, input int n, input logic [7:0] d0, d1, d2);
        logic a;
        nacks = 0;
        bus_start();
        wbyte({4'b1001, sel, 1'b0}, 1'b0, a); if (!a) nacks++;
        wbyte(p, 1'b0, a); if (!a) nacks++;
        if (n > 0) begin wbyte(d0, 1'b0, a); if (!a) nacks++; end
        if (n > 1) begin wbyte(d1, 1'b0, a); if (!a) nacks++; end
        if (n > 2) begin wbyte(d2, 1'b0, a); if (!a) nacks++; end
        bus_stop();
    endtask

    task automatic rd_seq(input int n, output logic [7:0] b0, b1, b2);
        logic a;
        b0 = 8'h00; b1 = 8'h00; b2 = 8'h00;
        bus_start();
        wbyte({4'b1001, sel, 1'b1}, 1'b0, a);
        rd_exp++;
        rbyte(n == 1, b0);
        if (n > 1) rbyte(n == 2, b1);
        if (n > 2) rbyte(1'b1, b2);
        bus_stop();
    endtask

    function automatic logic [7:0] exp_byte(input int p, input int idx);
        logic hi = (idx % 2 == 0);
        case (p)
            0: return hi ? temp[15:8] : temp[7:0];
            1: return exp_cfg;
            2: return hi ? exp_hyst[15:8] : exp_hyst[7:0];
            3: return hi ? exp_trip[15:8] : exp_trip[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        wq(5); rst_n = 1'b1; wq(20);
        // R1 reset state
        check("R1 cfg", cfg, 8'h00);
        check("R1 hyst", hyst, 16'h4B00);
        check("R1 trip", trip, 16'h5000);
        check("R1 pull", sda_pull, 0);
        // R3: read with no pointer write uses the reset pointer (temperature)
        rd_seq(2, r0, r1, r2);
        check("R3 temp hi", r0, 8'h19);
        check("R3 temp lo", r1, 8'hA0);
        check("R9 one strobe", rd_cnt, 1);

        // R2 address sweep over every select value and target
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 8; a++) begin
                sel = 3'(s); wq();
                bus_start();
                wbyte({4'b1001, 3'(a), 1'b0}, 1'b0, ack);
                bus_stop();
                check("R2 address ack", ack, (a == s));
            end
        end
        sel = 3'd5;

        // R6 / R4 / R13 writes
        wr_seq(8'h01, 1, 8'hFF, 8'h00, 8'h00); exp_cfg = 8'h3F;
        check("R6 cfg reserved", cfg, 8'h3F);
        check("R13 cfg acks", nacks, 0);
        wr_seq(8'h02, 3, 8'h12, 8'h34, 8'h99); exp_hyst = 16'h1230;
        check("R4 R6 hyst", hyst, 16'h1230);
        check("R13 extra byte ack", nacks, 0);
        wr_seq(8'h03, 2, 8'hA5, 8'hFF, 8'h00); exp_trip = 16'hA5F0;
        check("R4 R6 trip", trip, 16'hA5F0);

        // R5 writes to temperature ignored, R3 pointer persists
        wr_seq(8'h00, 2, 8'h55, 8'hAA, 8'h00);
        check("R5 temp write acked", nacks, 0);
        rd_seq(2, r0, r1, r2);
        check("R5 temp hi", r0, 8'h19);
        check("R5 temp lo", r1, 8'hA0);

        // R3 / R4 / R10 pointer sweep with three-byte reads
        for (int p = 0; p < 8; p++) begin
            wr_seq(8'(p), 0, 8'h00, 8'h00, 8'h00);
            if (p == 4) os_exp++;
            rd_seq(3, r0, r1, r2);
            check("R3 R4 byte0", r0, exp_byte(p, 0));
            check("R4 byte1", r1, exp_byte(p, 1));
            check("R4 byte2", r2, exp_byte(p, 2));
        end
        check("R10 shot from pointer", os_cnt, os_exp);

        // R7 repeated start
        bus_start();
        wbyte({4'b1001, sel, 1'b0}, 1'b0, ack);
        wbyte(8'h02, 1'b0, ack);
        bus_start();
        wbyte({4'b1001, sel, 1'b1}, 1'b0, ack); rd_exp++;
        rbyte(1'b0, r0); rbyte(1'b1, r1);
        bus_stop();
        check("R7 repstart hi", r0, 8'h12);
        check("R7 repstart lo", r1, 8'h30);

        // R5 snapshot: change temperature between the two bytes
        wr_seq(8'h00, 0, 8'h00, 8'h00, 8'h00);
        bus_start();
        wbyte({4'b1001, sel, 1'b1}, 1'b0, ack); rd_exp++;
        rbyte(1'b0, r0);
        temp = 16'h7D30;
        rbyte(1'b1, r1);
        bus_stop();
        check("R5 snapshot hi", r0, 8'h19);
        check("R5 snapshot lo", r1, 8'hA0);
        rd_seq(2, r0, r1, r2);
        check("R5 new sample", {r0, r1}, 16'h7D30);

        // R8 release after not-acknowledge
        wr_seq(8'h01, 0, 8'h00, 8'h00, 8'h00);
        bus_start();
        wbyte({4'b1001, sel, 1'b1}, 1'b0, ack); rd_exp++;
        rbyte(1'b1, r0);
        begin
            int low = 0;
            for (int i = 0; i < 9; i++) begin
                m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
                if (!sda_line || sda_pull) low++;
                wq(); m_scl = 1'b0; wq();
            end
            check("R8 released after nack", low, 0);
        end
        bus_stop();
        check("R8 cfg byte", r0, 8'h3F);

        // R10 one-shot writes discard data
        os_exp = os_cnt + 3;
        wr_seq(8'h04, 2, 8'h77, 8'h66, 8'h00);
        check("R10 shot count", os_cnt, os_exp);
        check("R10 cfg kept", cfg, 8'h3F);
        check("R10 hyst kept", hyst, 16'h1230);
        rd_seq(1, r0, r1, r2);
        check("R10 read zero", r0, 8'h00);

        // R11 timeout: slave drives 0 for bit 7 and SCL stalls low
        bus_start();
        wbyte({4'b1001, sel, 1'b1}, 1'b0, ack); rd_exp++;
        wq(1000);
        check("R11 held before timeout", sda_pull, 1);
        wq(1200);
        check("R11 released after timeout", sda_pull, 0);
        bus_stop();
        wr_seq(8'h01, 0, 8'h00, 8'h00, 8'h00);
        rd_seq(1, r0, r1, r2);
        check("R11 served after timeout", r0, 8'h3F);

        // R12 glitches on SCL and SDA inside a write
        bus_start();
        wbyte({4'b1001, sel, 1'b0}, 1'b0, ack);
        wbyte(8'h01, 1'b0, ack);
        m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
        wbyte(8'h2A, 1'b1, ack);
        bus_stop();
        check("R12 glitch ack", ack, 1);
        check("R12 glitch cfg", cfg, 8'h2A);

        check("R9 strobe count", rd_cnt, rd_exp);
        summary();
        $finish;
    end
endmodule